// File: doc/BRIEF.md
# Buffered Edge-Aligned PWM Timer

This block is an up-counting timer that drives a single edge-aligned pulse-width-modulated output. A programmable prescaler divides the system clock to produce count enables, and each count enable advances the counter by one. The output is high from the start of each counter period until the count reaches the active compare value, so the duty cycle is set by that value. The counter keeps running, and keeps flagging its wrap-around, whether or not the waveform is enabled.

The host supplies a new duty value through a small valid/ready write port. The value is held in a shadow register and becomes the active compare only when the counter wraps from its maximum to zero. This means a period that is already under way always completes with a consistent pulse. The port never applies back-pressure: `cmp_wr_ready` is tied high, and a write is taken in every cycle in which `cmp_wr_valid` is high. A later write that arrives before a wrap replaces the earlier pending value. If a write arrives in the same cycle as a load, the value that was already pending goes active and the new value stays pending.

An external gate input can stop counting, and this can be enabled or disabled. A sticky overflow flag and a one-cycle interrupt pulse report every wrap.

Top module: `edge_pwm_timer`

## Requirements
- R1: After reset, `pwm_out`, `ovf_flag` and `ovf_irq` are 0, and `cmp_wr_ready` is 1.
- R2: The counter is 8 bits wide and counts up, wrapping from 0xFF to 0x00. With prescale setting 0, consecutive wraps are 256 clocks apart. Each wrap raises `ovf_irq` for exactly one cycle, in the cycle in which the count reads 0x00.
- R3: While the waveform is enabled and the active compare value C is nonzero, `pwm_out` is high while the count is below C. It goes high when the count is 0x00 and low when the count equals C, giving C high cycles in every 256-count period.
- R4: An active compare value of 0x00 keeps `pwm_out` low for the whole period. The low condition wins over the high condition at count 0x00.
- R5: A compare value written through the valid/ready port while the waveform is enabled has no effect on the period in progress. It becomes active at the next 0xFF-to-0x00 wrap.
- R6: With prescale setting N (4 bits), the counter advances once every N+1 clocks, so consecutive wraps are 256*(N+1) clocks apart.
- R7: The counter runs only while `run_en` is 1 and either `gate_en` is 0 or `gate_in` is 1. Otherwise the count and `pwm_out` hold their values, and no wrap or interrupt occurs.
- R8: `ovf_flag` is set by every wrap and stays set until a one-cycle `ovf_clr` pulse clears it. If a clear and a wrap coincide, the flag stays set.
- R9: When `pwm_en` is 0, `pwm_out` is 0 from the next cycle on, and a pending compare value is made active immediately instead of waiting for a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Counter run enable |
| gate_en | input | 1 | Lets `gate_in` halt the counter when 1 |
| gate_in | input | 1 | External gate; counting allowed while high (if gating enabled) |
| presc_sel | input | 4 | Prescale setting N; one count every N+1 clocks |
| cmp_wr_valid | input | 1 | Compare write request |
| cmp_wr_ready | output | 1 | Compare write accept, always 1 |
| cmp_wr_data | input | 8 | Compare value to buffer |
| pwm_en | input | 1 | Waveform enable |
| ovf_clr | input | 1 | One-cycle clear of the overflow flag |
| pwm_out | output | 1 | PWM waveform |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | One-cycle interrupt request per wrap |

## Verification
The bench builds the block with its default 8-bit counter and 4-bit prescaler. Prescale setting 0 gives 256-clock periods, so the high time can be counted cycle by cycle for duty values 0x00, 0x01, 0x40 and 0xFF. Because the period is short, a write or a waveform disable can be placed at a known count inside a period, and a clear can be made to land on the exact wrap cycle. Settings 3 and 15 check the divider over periods of 1024 and 4096 clocks.

// File: rtl/epwm_pkg.sv
package epwm_pkg;
  localparam int DEF_CNT_W = 8;
  localparam int DEF_PS_W  = 4;

  typedef enum logic {
    WAVE_LOW  = 1'b0,
    WAVE_HIGH = 1'b1
  } wave_lvl_e;
endpackage

// File: rtl/epwm_prescaler.sv
module epwm_prescaler #(
  parameter int PS_W = epwm_pkg::DEF_PS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] div_sel,
  output logic            tick
);
  localparam logic [PS_W-1:0] PS_ONE = PS_W'(1);

  logic [PS_W-1:0] div_q;
  logic            hit;

  // A lowered setting must not strand the divider above it, hence >=.
  assign hit  = (div_q >= div_sel);
  assign tick = run && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (!run || hit) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + PS_ONE;
    end
  end
endmodule

// File: rtl/epwm_counter.sv
module epwm_counter #(
  parameter int CNT_W = epwm_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  assign cnt_nxt = tick ? (cnt_q + CNT_ONE) : cnt_q;
  assign wrap    = tick && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/epwm_cmp_buffer.sv
module epwm_cmp_buffer #(
  parameter int CNT_W = epwm_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load,
  output logic [CNT_W-1:0] act_q,
  output logic [CNT_W-1:0] act_nxt
);
  logic [CNT_W-1:0] shadow_q;
  logic             pend_q;
  logic             take;
  logic             xfer;

  assign wr_ready = 1'b1;
  assign take     = wr_valid && wr_ready;
  assign xfer     = load && pend_q;
  assign act_nxt  = xfer ? shadow_q : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
      act_q    <= '0;
    end else begin
      act_q <= act_nxt;
      if (take) begin
        shadow_q <= wr_data;
        pend_q   <= 1'b1;
      end else if (xfer) begin
        pend_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/epwm_wave.sv
module epwm_wave #(
  parameter int CNT_W = epwm_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_en,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] act_nxt,
  input  logic             wrap,
  input  logic             ovf_clr,
  output logic             pwm_q,
  output logic             flag_q,
  output logic             irq_q
);
  import epwm_pkg::*;

  wave_lvl_e lvl_nxt;

  // Below the compare value means the set at 00h has happened and the
  // clear at the match has not; a zero compare is never exceeded.
  always_comb begin
    lvl_nxt = WAVE_LOW;
    if (pwm_en && (cnt_nxt < act_nxt)) begin
      lvl_nxt = WAVE_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pwm_q  <= (lvl_nxt == WAVE_HIGH);
      flag_q <= wrap || (flag_q && !ovf_clr);
      irq_q  <= wrap;
    end
  end
endmodule

// File: rtl/edge_pwm_timer.sv
module edge_pwm_timer #(
  parameter int CNT_W = epwm_pkg::DEF_CNT_W,
  parameter int PS_W  = epwm_pkg::DEF_PS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             gate_en,
  input  logic             gate_in,
  input  logic [PS_W-1:0]  presc_sel,
  input  logic             cmp_wr_valid,
  output logic             cmp_wr_ready,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             pwm_en,
  input  logic             ovf_clr,
  output logic             pwm_out,
  output logic             ovf_flag,
  output logic             ovf_irq
);
  logic             run;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] act_cmp;
  logic [CNT_W-1:0] act_nxt;
  logic             cmp_load;

  assign run      = run_en && (!gate_en || gate_in);
  assign cmp_load = wrap || !pwm_en;

  epwm_prescaler #(.PS_W(PS_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .div_sel (presc_sel),
    .tick    (tick)
  );

  epwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .wrap    (wrap)
  );

  epwm_cmp_buffer #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (cmp_wr_valid),
    .wr_ready (cmp_wr_ready),
    .wr_data  (cmp_wr_data),
    .load     (cmp_load),
    .act_q    (act_cmp),
    .act_nxt  (act_nxt)
  );

  epwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_en  (pwm_en),
    .cnt_nxt (cnt_nxt),
    .act_nxt (act_nxt),
    .wrap    (wrap),
    .ovf_clr (ovf_clr),
    .pwm_q   (pwm_out),
    .flag_q  (ovf_flag),
    .irq_q   (ovf_irq)
  );
endmodule

// File: rtl/epwm_checker.sv
module epwm_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             gate_en,
  input logic             gate_in,
  input logic             pwm_en,
  input logic             ovf_clr,
  input logic             pwm_out,
  input logic             ovf_flag,
  input logic             ovf_irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] act_cmp
);
  // R8: an interrupt pulse always comes with the flag set
  a_r8_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_flag);

  // R8: the flag drops only after a clear request
  a_r8_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(ovf_clr));

  // R9: waveform disabled forces a low output next cycle
  a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> !pwm_out);

  // R7: without the run condition no wrap can be reported
  a_r7_halt_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_en && (!gate_en || gate_in)) |=> !ovf_irq);

  // R4: a high output needs a nonzero compare above the count
  a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out |-> (act_cmp != '0) && (cnt_q < act_cmp));

  // R5: the active compare changes only at a wrap or while disabled
  a_r5_load_point: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_cmp) |-> (cnt_q == '0) || !$past(pwm_en));
endmodule

bind edge_pwm_timer epwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .gate_en  (gate_en),
  .gate_in  (gate_in),
  .pwm_en   (pwm_en),
  .ovf_clr  (ovf_clr),
  .pwm_out  (pwm_out),
  .ovf_flag (ovf_flag),
  .ovf_irq  (ovf_irq),
  .cnt_q    (cnt_q),
  .act_cmp  (act_cmp)
);

// File: tb/test_edge_pwm_timer.sv
`timescale 1ns/1ps
module test_edge_pwm_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       gate_en = 1'b0;
  logic       gate_in = 1'b0;
  logic [3:0] presc_sel = 4'd0;
  logic       cmp_wr_valid = 1'b0;
  logic       cmp_wr_ready;
  logic [7:0] cmp_wr_data = 8'd0;
  logic       pwm_en = 1'b0;
  logic       ovf_clr = 1'b0;
  logic       pwm_out;
  logic       ovf_flag;
  logic       ovf_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_pwm_timer i_edge_pwm_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .gate_en(gate_en),
    .gate_in(gate_in), .presc_sel(presc_sel), .cmp_wr_valid(cmp_wr_valid),
    .cmp_wr_ready(cmp_wr_ready), .cmp_wr_data(cmp_wr_data), .pwm_en(pwm_en),
    .ovf_clr(ovf_clr), .pwm_out(pwm_out), .ovf_flag(ovf_flag),
    .ovf_irq(ovf_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cmp(input logic [7:0] v);
    cmp_wr_data  = v;
    cmp_wr_valid = 1'b1;
    @(negedge clk);
    cmp_wr_valid = 1'b0;
  endtask

  // Returns at the negedge where the wrap interrupt is visible (count 00h).
  task automatic sync_wrap();
    do @(negedge clk); while (!ovf_irq);
  endtask

  task automatic measure_high(output int n);
    n = 0;
    for (int i = 0; i < 256; i++) begin
      n += int'(pwm_out);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check(pwm_out == 1'b0, "R1 pwm", int'(pwm_out), 0);
    check(ovf_flag == 1'b0, "R1 flag", int'(ovf_flag), 0);
    check(ovf_irq == 1'b0, "R1 irq", int'(ovf_irq), 0);
    check(cmp_wr_ready == 1'b1, "R1 ready", int'(cmp_wr_ready), 1);
  endtask

  task automatic t_duty(input logic [7:0] c, input string req);
    int n;
    write_cmp(c);
    sync_wrap();
    measure_high(n);
    check(n == int'(c), req, n, int'(c));
  endtask

  task automatic t_period_len(input logic [3:0] ps, input int exp, input string req);
    int n;
    presc_sel = ps;
    sync_wrap();
    n = 0;
    do begin @(negedge clk); n++; end while (!ovf_irq);
    check(n == exp, req, n, exp);
  endtask

  task automatic t_buffer();
    int n;
    write_cmp(8'h40);
    sync_wrap();
    n = 0;
    for (int i = 0; i < 256; i++) begin
      n += int'(pwm_out);
      if (i == 10) begin cmp_wr_data = 8'h08; cmp_wr_valid = 1'b1; end
      if (i == 11) cmp_wr_valid = 1'b0;
      @(negedge clk);
    end
    check(n == 64, "R5 period in progress", n, 64);
    check(ovf_irq == 1'b1, "R2 wrap after 256", int'(ovf_irq), 1);
    measure_high(n);
    check(n == 8, "R5 next period", n, 8);
  endtask

  task automatic t_disable();
    write_cmp(8'h40);
    sync_wrap();
    repeat (2) @(negedge clk);
    write_cmp(8'h10);
    repeat (2) @(negedge clk);
    pwm_en = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R9 forced low", int'(pwm_out), 0);
    pwm_en = 1'b1;
    repeat (2) @(negedge clk);
    check(pwm_out == 1'b1, "R3 high below compare", int'(pwm_out), 1);
    repeat (24) @(negedge clk);
    check(pwm_out == 1'b0, "R9 pending loaded", int'(pwm_out), 0);
  endtask

  task automatic t_flag();
    check(ovf_flag == 1'b1, "R8 sticky", int'(ovf_flag), 1);
    sync_wrap();
    repeat (5) @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check(ovf_flag == 1'b0, "R8 cleared", int'(ovf_flag), 0);
    repeat (249) @(negedge clk);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check(ovf_irq == 1'b1, "R2 irq on wrap", int'(ovf_irq), 1);
    check(ovf_flag == 1'b1, "R8 wrap beats clear", int'(ovf_flag), 1);
    @(negedge clk);
    check(ovf_irq == 1'b0, "R2 irq one cycle", int'(ovf_irq), 0);
  endtask

  task automatic hold_check(input string req);
    int bad;
    logic p;
    bad = 0;
    @(negedge clk);
    p = pwm_out;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (ovf_irq || pwm_out != p) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic wait_irq(input string req);
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!ovf_irq && n < 300);
    check(ovf_irq == 1'b1, req, int'(ovf_irq), 1);
  endtask

  task automatic t_gate();
    write_cmp(8'h40);
    sync_wrap();
    repeat (20) @(negedge clk);
    gate_en = 1'b1;
    gate_in = 1'b0;
    hold_check("R7 gate halts");
    check(pwm_out == 1'b1, "R7 output held", int'(pwm_out), 1);
    gate_in = 1'b1;
    wait_irq("R7 gate released");
    gate_en = 1'b0;
    gate_in = 1'b0;
    wait_irq("R7 gate ignored when off");
    run_en = 1'b0;
    hold_check("R7 run off halts");
    run_en = 1'b1;
    wait_irq("R7 run resumes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    pwm_en = 1'b1;
    run_en = 1'b1;
    t_duty(8'h40, "R3 duty 40h");
    t_duty(8'h01, "R3 duty 01h");
    t_duty(8'hFF, "R3 duty FFh");
    t_duty(8'h00, "R4 zero compare");
    t_buffer();
    t_disable();
    t_flag();
    t_period_len(4'd3, 1024, "R6 prescale 3");
    t_period_len(4'd15, 4096, "R6 prescale 15");
    t_period_len(4'd0, 256, "R2 period 256");
    t_gate();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule